// File: doc/BRIEF.md
# Central Bus Arbiter with Overlapped Grant

This block decides which of several masters may use a shared parallel bus next. Each master pulls its own active-low request line and watches its own active-low grant line. The arbiter looks at all requests on every clock and picks a winner. Masters are split into a high class and a low class, and a high-class request always beats a low-class one. Inside a class, the winner is either the lowest index or the next master in rotation after the last one that started a transaction. The chosen grant is registered, so it appears one clock after the requests that caused it.

Arbitration is not held back while the bus is busy. The grant for the next transaction can move while the current owner is still driving its frame. This hides the time spent arbitrating behind the data transfer. A granted master starts only when it sees the bus idle, meaning frame and ready are both deasserted. The arbiter treats the grant as used at the first clock where frame is low after a clock where the bus was idle. That start is what moves the rotation pointer. When nobody requests, the grant rests on a default master.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `gnt_n` is low only for master `PARK_ID`, with all other bits high.
- R2: In every cycle exactly one bit of `gnt_n` is low.
- R3: When every `req_n` bit is high at a clock edge, the grant after that edge is parked on `PARK_ID`.
- R4: A high-class request (a master whose `HI_MASK` bit is 1) at a clock edge gives the next grant to a high-class master, even when this means taking the grant away from a low-class master that has not started.
- R5: The grant is registered. `gnt_n` after an edge reflects the requests sampled at that edge, and it is low only for a requesting master or for the park master.
- R6: Grants keep moving while `frame_n` or `irdy_n` is low. A new request during a busy bus gets its grant one clock later.
- R7: A master whose `req_n` is high at an edge does not hold the grant after that edge, unless no master is requesting and it is the park master.
- R8: A start is the first edge where `frame_n` is low after an edge where both `frame_n` and `irdy_n` were high. The master that held the grant before that edge is the one that started.
- R9: With `ROUND_ROBIN` set, the search within a class begins at the master just after the most recent starter, wrapping from the top index back to index 0. The start edge already uses this new order. Frame staying low does not count as a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n | input | N_MASTERS | Active-low request, one bit per master |
| frame_n | input | 1 | Active-low bus frame, driven by the current owner |
| irdy_n | input | 1 | Active-low master ready |
| gnt_n | output | N_MASTERS | Active-low registered grant, one bit per master |

## Verification
The bench uses four masters. Master 3 is the only high-class master, master 0 is the park master, and round-robin is on.

- **Two low-class masters on an idle bus:** shows that the lowest index after the pointer wins.
- **A start while both stay requesting:** shows that the grant hops to the other master during the frame (overlap), not after it.
- **A continuing frame:** shows it is not mistaken for a second start.
- **A withdrawal, then a high-class arrival:** shows a grant being taken back before its owner starts.
- **Three low-class requesters with a chain of starts, including the wrap from index 3 to 0:** separates true rotation from fixed priority.

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int N_MASTERS = 4,
  parameter logic [N_MASTERS-1:0] HI_MASK = 4'b1000,
  parameter int PARK_ID = 0,
  parameter bit ROUND_ROBIN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_n,
  input  logic                 frame_n,
  input  logic                 irdy_n,
  output logic [N_MASTERS-1:0] gnt_n
);
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
  localparam logic [N_MASTERS-1:0] PARK_VEC = N_MASTERS'(1) << PARK_ID;

  logic [N_MASTERS-1:0] req, cls, gnt_q, win;
  logic [IW-1:0]        ptr_q, eff_ptr, owner, after_owner;
  logic                 frame_q, irdy_q, start;

  assign req   = ~req_n;
  assign start = frame_q & irdy_q & ~frame_n;
  assign cls   = |(req & HI_MASK) ? (req & HI_MASK) : req;
  assign gnt_n = ~gnt_q;

  always_comb begin
    owner = '0;
    for (int i = 0; i < N_MASTERS; i++)
      if (gnt_q[i]) owner = IW'(i);
  end

  assign after_owner = (int'(owner) == N_MASTERS - 1) ? '0 : owner + 1'b1;
  assign eff_ptr = !ROUND_ROBIN ? '0 : (start ? after_owner : ptr_q);

  always_comb begin
    logic found;
    int   j;
    win   = '0;
    found = 1'b0;
    for (int k = 0; k < N_MASTERS; k++) begin
      j = int'(eff_ptr) + k;
      if (j >= N_MASTERS) j = j - N_MASTERS;
      if (!found && cls[j]) begin
        win[j] = 1'b1;
        found  = 1'b1;
      end
    end
    if (!found) win = PARK_VEC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q   <= PARK_VEC;
      ptr_q   <= '0;
      frame_q <= 1'b1;
      irdy_q  <= 1'b1;
    end else begin
      gnt_q   <= win;
      ptr_q   <= eff_ptr;
      frame_q <= frame_n;
      irdy_q  <= irdy_n;
    end
  end
endmodule

// File: rtl/bus_grant_arbiter_checks.sv
module bus_grant_arbiter_checks #(
  parameter int N_MASTERS = 4,
  parameter logic [N_MASTERS-1:0] HI_MASK = 4'b1000,
  parameter int PARK_ID = 0,
  parameter bit ROUND_ROBIN = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] req_n,
  input logic                 frame_n,
  input logic                 irdy_n,
  input logic [N_MASTERS-1:0] gnt_n
);
  localparam logic [N_MASTERS-1:0] PARK_VEC = N_MASTERS'(1) << PARK_ID;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~gnt_n) == 1); // R2

  AST_PARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (&req_n) |=> (gnt_n == ~PARK_VEC)); // R3

  AST_HI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~req_n & HI_MASK)) |=> (|(~gnt_n & HI_MASK))); // R4

  AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&req_n)) |=> ((~gnt_n & $past(~req_n)) != '0)); // R5

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_withdraw
    AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_n[i] && !((&req_n) && i == PARK_ID)) |=> gnt_n[i]); // R7
  end
endmodule

bind bus_grant_arbiter bus_grant_arbiter_checks #(
  .N_MASTERS(N_MASTERS), .HI_MASK(HI_MASK), .PARK_ID(PARK_ID), .ROUND_ROBIN(ROUND_ROBIN)
) chk_i (.*);

// File: tb/bus_grant_arbiter_tb_top.sv
module bus_grant_arbiter_tb_top;
  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_n = 4'hF;
  logic       frame_n = 1'b1;
  logic       irdy_n = 1'b1;
  logic [3:0] gnt_n;
  item_t      sb[$];
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  bus_grant_arbiter #(.N_MASTERS(4), .HI_MASK(4'b1000), .PARK_ID(0), .ROUND_ROBIN(1'b1))
    dut_i (.clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n));

  task automatic check(input logic [3:0] exp, input string tag);
    checks++;
    if (gnt_n !== exp) begin
      fails++;
      $display("FAIL %s: gnt_n actual=%b expected=%b", tag, gnt_n, exp);
    end
  endtask

  task automatic step(input logic [3:0] rq, input logic f, input logic ir,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    req_n = rq; frame_n = f; irdy_n = ir;
    sb.push_back('{exp, tag});
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.exp, it.tag);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    #80000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin : driver
    repeat (2) @(negedge clk);
    check(4'b1110, "R1 park during reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(4'b1110, "R1 park after reset");
    step(4'b1111, 1, 1, 4'b1110, "R3 idle park");
    step(4'b1001, 1, 1, 4'b1101, "R5 lowest after pointer");
    step(4'b1001, 0, 1, 4'b1011, "R6 R8 R9 overlap handover on start");
    step(4'b1001, 0, 0, 4'b1011, "R9 continuing frame is no start");
    step(4'b1101, 0, 0, 4'b1101, "R7 withdrawal moves grant");
    step(4'b0101, 0, 0, 4'b0111, "R4 high class preempts");
    step(4'b1111, 1, 1, 4'b1110, "R3 park after release");
    step(4'b1000, 1, 1, 4'b1011, "R9 pointer order");
    step(4'b1000, 0, 1, 4'b1110, "R9 wrap after start of 2");
    step(4'b1000, 1, 1, 4'b1110, "R9 pointer held");
    step(4'b1000, 0, 1, 4'b1101, "R8 R9 start of 0 rotates");
    step(4'b1000, 0, 0, 4'b1101, "R6 busy bus hold");
    step(4'b0111, 0, 0, 4'b0111, "R6 R4 grant during busy bus");
    step(4'b1111, 1, 1, 4'b1110, "R3 final park");
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule